// File: doc/BRIEF.md
# Multi-Cycle 32-bit RISC Subset Core

This block is a small 32-bit processor core that runs each instruction over several clock steps instead of one. A finite-state controller walks every instruction through a fetch step and a decode step. Depending on the opcode, it then adds an execute step, a memory or register-completion step, and a final load write-back step. One arithmetic unit is reused in every step. It advances the program counter, forms the branch target and does the real work of the instruction. Internal holding registers keep intermediate values from one step to the next: the instruction register, the two operand latches, the result latch and the memory-data latch.

A single memory port carries both instruction fetches and data accesses. It has an address, write data, read data, a read strobe and a write strobe. The surrounding system answers a read with data in the same cycle and commits a write on the rising edge at which the write strobe is high. The supported instructions are word load, word store, branch-if-equal, an absolute jump, and the register-to-register operations add, subtract, and, or and signed set-less-than.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after release, the core drives a fetch: read strobe high, write strobe low, address 0.
- R2: Every instruction starts with one cycle that reads the word at the program counter. Without a branch or jump, the next instruction is fetched from that address plus 4.
- R3: Instruction length in cycles depends on the opcode field IR[31:26]. Register-type (0) takes 4, load (35) takes 5, store (43) takes 4, branch-if-equal (4) takes 3 and jump (2) takes 3. Strobes are active only in the fetch step and in the fourth step of loads and stores.
- R4: For register-type instructions, rd = IR[15:11] receives rs op rt, with rs = IR[25:21] and rt = IR[20:16]. The funct field IR[5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R5: A load or store uses the address rs plus the sign-extended IR[15:0]. In its fourth cycle a store raises the write strobe with rt's value on the write data. In the same cycle a load raises the read strobe, and rt receives the read word one cycle later.
- R6: Branch-if-equal changes the next fetch address to PC+4 plus the sign-extended IR[15:0] times 4 when rs equals rt. Otherwise the next fetch is at PC+4.
- R7: A jump fetches next from the upper four bits of PC+4, followed by IR[25:0] and two zero bits.
- R8: Register 0 always reads as zero, including after an instruction that names it as destination.
- R9: An opcode other than 0, 2, 4, 35 and 43 ends after its decode cycle (2 cycles) with no register or memory change, and fetching resumes at PC+4.
- R10: Every store's data is committed to memory, so that memory matches an instruction-level model after the program ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe, committed on the rising edge |

## Verification
The bench checks the memory port in every cycle, half a period after the edge that set it, against a cycle-level prediction built from an instruction-level model. The fetch read is due in an instruction's first cycle. A load's read and a store's write are due in its fourth cycle. The next fetch is due right after the 2, 3, 4 or 5 cycles that the opcode sets. Register results leave the core only through stores, so each R-type and load value is checked in the fourth cycle of a later store that names it. After the final jump-to-self, the stored words in memory are compared with the model.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_MEM    = 3'd3,
      ST_WB     = 3'd4
   } state_t;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_t;

   typedef enum logic [1:0] {AM_ADD, AM_SUB, AM_FUNCT} alu_mode_t;
   typedef enum logic [1:0] {BS_REG, BS_FOUR, BS_IMM, BS_IMM_SH} bsel_t;
   typedef enum logic [1:0] {PS_ALU, PS_LATCH, PS_JUMP} psel_t;

   localparam logic [5:0] OPC_RTYPE = 6'd0;
   localparam logic [5:0] OPC_JUMP  = 6'd2;
   localparam logic [5:0] OPC_BEQ   = 6'd4;
   localparam logic [5:0] OPC_LOAD  = 6'd35;
   localparam logic [5:0] OPC_STORE = 6'd43;

   typedef struct packed {
      logic      ir_we;
      logic      pc_we;
      logic      pc_we_eq;
      psel_t     pc_sel;
      logic      a_from_reg;
      bsel_t     b_sel;
      alu_mode_t mode;
      logic      mem_rd;
      logic      mem_wr;
      logic      addr_from_latch;
      logic      ab_we;
      logic      res_we;
      logic      mdr_we;
      logic      rf_we;
      logic      rf_dst_rd;
      logic      rf_from_mdr;
   } ctl_t;

endpackage

// File: rtl/mc_alu_dec.sv
module mc_alu_dec
   import mc_pkg::*;
(
   input  alu_mode_t  mode,
   input  logic [3:0] funct_lo,
   output alu_op_t    op
);
   always_comb begin
      op = ALU_ADD;
      unique case (mode)
         AM_ADD: op = ALU_ADD;
         AM_SUB: op = ALU_SUB;
         default: begin
            case (funct_lo)
               4'b0010: op = ALU_SUB;
               4'b0100: op = ALU_AND;
               4'b0101: op = ALU_OR;
               4'b1010: op = ALU_SLT;
               default: op = ALU_ADD;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_t      op,
   output logic [W-1:0] y,
   output logic         zero
);
   always_comb begin
      unique case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SUB: y = a - b;
         ALU_SLT: y = W'($signed(a) < $signed(b));
         default: y = a + b;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W       = 32,
   parameter int DEPTH   = 32,
   parameter bit ZERO_R0 = 1'b1,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);
   logic [W-1:0] regs [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      end else if (we) begin
         regs[wa] <= wd;
      end
   end

   generate
      if (ZERO_R0) begin : g_hard_zero
         assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
         assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
      end else begin : g_plain
         assign rd1 = regs[ra1];
         assign rd2 = regs[ra2];
      end
   endgenerate
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   output state_t     state,
   output ctl_t       ctl
);
   state_t nxt;
   logic   known;

   assign known = (opcode == OPC_RTYPE) || (opcode == OPC_JUMP) ||
                  (opcode == OPC_BEQ)   || (opcode == OPC_LOAD) ||
                  (opcode == OPC_STORE);

   always_comb begin
      nxt = ST_FETCH;
      unique case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: nxt = known ? ST_EXEC : ST_FETCH;
         ST_EXEC:   nxt = (opcode == OPC_RTYPE || opcode == OPC_LOAD ||
                           opcode == OPC_STORE) ? ST_MEM : ST_FETCH;
         ST_MEM:    nxt = (opcode == OPC_LOAD) ? ST_WB : ST_FETCH;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FETCH;
      else        state <= nxt;
   end

   always_comb begin
      ctl = '0;
      unique case (state)
         ST_FETCH: begin
            ctl.mem_rd = 1'b1;
            ctl.ir_we  = 1'b1;
            ctl.b_sel  = BS_FOUR;
            ctl.pc_we  = 1'b1;
            ctl.pc_sel = PS_ALU;
         end
         ST_DECODE: begin
            ctl.ab_we  = 1'b1;
            ctl.b_sel  = BS_IMM_SH;
            ctl.res_we = 1'b1;
         end
         ST_EXEC: begin
            ctl.a_from_reg = 1'b1;
            if (opcode == OPC_RTYPE) begin
               ctl.mode   = AM_FUNCT;
               ctl.res_we = 1'b1;
            end else if (opcode == OPC_LOAD || opcode == OPC_STORE) begin
               ctl.b_sel  = BS_IMM;
               ctl.res_we = 1'b1;
            end else if (opcode == OPC_BEQ) begin
               ctl.mode     = AM_SUB;
               ctl.pc_we_eq = 1'b1;
               ctl.pc_sel   = PS_LATCH;
            end else if (opcode == OPC_JUMP) begin
               ctl.pc_we  = 1'b1;
               ctl.pc_sel = PS_JUMP;
            end
         end
         ST_MEM: begin
            if (opcode == OPC_RTYPE) begin
               ctl.rf_we     = 1'b1;
               ctl.rf_dst_rd = 1'b1;
            end else if (opcode == OPC_LOAD) begin
               ctl.mem_rd          = 1'b1;
               ctl.addr_from_latch = 1'b1;
               ctl.mdr_we          = 1'b1;
            end else if (opcode == OPC_STORE) begin
               ctl.mem_wr          = 1'b1;
               ctl.addr_from_latch = 1'b1;
            end
         end
         default: begin
            ctl.rf_we       = 1'b1;
            ctl.rf_from_mdr = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          REG_CNT  = 32,
   parameter bit          ZERO_R0  = 1'b1,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            mem_rd,
   output logic            mem_wr
);
   localparam int RIDX_W = $clog2(REG_CNT);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mc_core: instruction format needs XLEN of 32");
      end
      if (RIDX_W != 5) begin : g_bad_regs
         $error("mc_core: register fields are 5 bits, REG_CNT must be 32");
      end
   endgenerate

   state_t          state;
   ctl_t            ctl;
   logic [XLEN-1:0] pc, ir, a_q, b_q, res_q, mdr_q;
   logic [XLEN-1:0] rs_data, rt_data, alu_a, alu_b, alu_y, pc_next, imm_sx, rf_wd;
   logic            alu_zero;
   alu_op_t         alu_op;
   logic [5:0]      opcode;
   logic [RIDX_W-1:0] f_rs, f_rt, f_rd, rf_wa;

   assign opcode = ir[31:26];
   assign f_rs   = ir[25:21];
   assign f_rt   = ir[20:16];
   assign f_rd   = ir[15:11];
   assign imm_sx = {{(XLEN-16){ir[15]}}, ir[15:0]};

   mc_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .state  (state),
      .ctl    (ctl)
   );

   assign rf_wa = ctl.rf_dst_rd ? f_rd : f_rt;
   assign rf_wd = ctl.rf_from_mdr ? mdr_q : res_q;

   mc_regfile #(.W(XLEN), .DEPTH(REG_CNT), .ZERO_R0(ZERO_R0)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra1   (f_rs),
      .ra2   (f_rt),
      .rd1   (rs_data),
      .rd2   (rt_data),
      .we    (ctl.rf_we),
      .wa    (rf_wa),
      .wd    (rf_wd)
   );

   assign alu_a = ctl.a_from_reg ? a_q : pc;
   always_comb begin
      unique case (ctl.b_sel)
         BS_FOUR:   alu_b = XLEN'(4);
         BS_IMM:    alu_b = imm_sx;
         BS_IMM_SH: alu_b = {imm_sx[XLEN-3:0], 2'b00};
         default:   alu_b = b_q;
      endcase
   end

   mc_alu_dec u_dec (
      .mode     (ctl.mode),
      .funct_lo (ir[3:0]),
      .op       (alu_op)
   );

   mc_alu #(.W(XLEN)) u_alu (
      .a    (alu_a),
      .b    (alu_b),
      .op   (alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   always_comb begin
      unique case (ctl.pc_sel)
         PS_LATCH: pc_next = res_q;
         PS_JUMP:  pc_next = {pc[XLEN-1:XLEN-4], ir[25:0], 2'b00};
         default:  pc_next = alu_y;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc    <= RESET_PC;
         ir    <= '0;
         a_q   <= '0;
         b_q   <= '0;
         res_q <= '0;
         mdr_q <= '0;
      end else begin
         if (ctl.pc_we || (ctl.pc_we_eq && alu_zero)) pc <= pc_next;
         if (ctl.ir_we)  ir    <= mem_rdata;
         if (ctl.ab_we) begin
            a_q <= rs_data;
            b_q <= rt_data;
         end
         if (ctl.res_we) res_q <= alu_y;
         if (ctl.mdr_we) mdr_q <= mem_rdata;
      end
   end

   assign mem_addr  = ctl.addr_from_latch ? res_q : pc;
   assign mem_wdata = b_q;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
   import mc_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        mem_rd,
   input logic        mem_wr,
   input state_t      state,
   input logic [31:0] pc,
   input logic [31:0] ir,
   input logic [31:0] a_q
);
   logic [5:0] opc;
   logic       opc_known;
   assign opc       = ir[31:26];
   assign opc_known = (opc == OPC_RTYPE) || (opc == OPC_JUMP) || (opc == OPC_BEQ) ||
                      (opc == OPC_LOAD) || (opc == OPC_STORE);

   AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R3
   AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |=> (pc == $past(pc) + 32'd4)); // R2
   AST_WRITE_IN_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (state == ST_MEM)); // R5
   AST_WB_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WB) |-> ($past(state) == ST_MEM)); // R3
   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && opc == OPC_JUMP) |=> (pc[27:0] == {$past(ir[25:0]), 2'b00})); // R7
   AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE && ir[25:21] == 5'd0) |=> (a_q == 32'd0)); // R8
   AST_UNKNOWN_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE && !opc_known) |=> (state == ST_FETCH)); // R9
endmodule

bind mc_core mc_core_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr),
   .state  (state),
   .pc     (pc),
   .ir     (ir),
   .a_q    (a_q)
);

// File: tb/mc_core_tb.sv
module mc_core_tb;
   localparam time CLK_PERIOD = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr;

   always #(CLK_PERIOD/2) clk = ~clk;

   mc_core u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr)
   );

   logic [31:0] mem  [1024];
   logic [31:0] mref [1024];
   logic [31:0] regs [32];
   int n_cmp = 0, n_bad = 0, p = 0;
   bit finished = 1'b0;

   assign mem_rdata = mem[mem_addr[11:2]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] enc_j(int target_word);
      return {6'd2, 26'(target_word)};
   endfunction
   function automatic logic [31:0] sx(logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction
   function automatic logic [31:0] alu_ref(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
      case (fn)
         6'h22:   return a - b;
         6'h24:   return a & b;
         6'h25:   return a | b;
         6'h2A:   return {31'd0, $signed(a) < $signed(b)};
         default: return a + b;
      endcase
   endfunction
   function automatic logic [5:0] pick_funct(int k);
      case (k)
         0: return 6'h20;
         1: return 6'h22;
         2: return 6'h24;
         3: return 6'h25;
         default: return 6'h2A;
      endcase
   endfunction

   task automatic put(logic [31:0] w);
      mem[p] = w;
      p++;
   endtask

   task automatic chk_bus(input logic e_rd, input logic e_wr, input logic [31:0] e_addr,
                          input logic [31:0] e_wd, input string req);
      bit bad;
      bad = (mem_rd !== e_rd) || (mem_wr !== e_wr) ||
            ((e_rd || e_wr) && (mem_addr !== e_addr)) || (e_wr && (mem_wdata !== e_wd));
      n_cmp++;
      if (bad) begin
         n_bad++;
         $display("FAIL %s: rd=%b wr=%b addr=%h wdata=%h, expected rd=%b wr=%b addr=%h wdata=%h",
                  req, mem_rd, mem_wr, mem_addr, mem_wdata, e_rd, e_wr, e_addr, e_wd);
      end
      @(negedge clk);
      #1;
   endtask

   task automatic build_program();
      int t, r;
      for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
      mem[256] = 32'h8000_0000;
      mem[257] = 32'd1;
      for (int i = 258; i < 264; i++) mem[i] = $urandom;
      mem[264] = 32'h0000_0700;
      for (int i = 1; i <= 8; i++) put(enc_i(6'd35, 0, i, 16'(32'h400 + 4*(i-1))));
      put(enc_i(6'd35, 0, 9, 16'h0420));
      put(enc_i(6'd43, 9, 1, 16'hFFF8));            // R5 negative offset -> 0x6F8
      put(enc_r(1, 2, 3, 6'h2A));                    // R4 signed slt: min < 1
      put(enc_r(1, 2, 0, 6'h20));                    // R8 write to r0
      put(enc_i(6'd43, 0, 0, 16'h0600));             // R8 store r0
      t = p + 2; put(enc_j(t)); put(enc_r(2, 2, 1, 6'h20));   // R7 skip
      put(enc_i(6'd4, 0, 0, 16'd1)); put(enc_r(2, 2, 1, 6'h20)); // R6 taken
      put(enc_i(6'd4, 1, 2, 16'd1)); put(enc_r(1, 2, 4, 6'h22)); // R6 not taken
      put({6'h3F, 26'h0123456});                     // R9 unknown
      for (int k = 0; k < 60; k++) begin
         r = $urandom_range(0, 19);
         if (r <= 12)
            put(enc_r($urandom_range(0, 8), $urandom_range(0, 8), $urandom_range(0, 8),
                      pick_funct($urandom_range(0, 4))));
         else if (r <= 14)
            put(enc_i(6'd43, 0, $urandom_range(0, 8), 16'(32'h600 + 4*$urandom_range(1, 15))));
         else if (r == 15)
            put(enc_i(6'd35, 0, $urandom_range(1, 8), 16'(32'h400 + 4*$urandom_range(0, 8))));
         else if (r <= 17) begin
            t = $urandom_range(1, 8);
            put(enc_i(6'd4, t, ($urandom_range(0, 1) == 1) ? t : $urandom_range(1, 8), 16'd1));
         end else if (r == 18) begin
            t = p + 2;
            put(enc_j(t));
         end else
            put({($urandom_range(0, 1) == 1) ? 6'h3F : 6'h08, 26'($urandom)});
      end
      for (int i = 1; i <= 8; i++) put(enc_i(6'd43, 0, i, 16'(32'h680 + 4*(i-1))));
      t = p; put(enc_j(t));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=timeout expected=halt");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] pc, npc, ins, ea;
      logic [5:0]  op;
      int          rs, rt, rd;
      string       tag;
      bit          halted;
      void'($urandom(32'h5EED_0042));
      build_program();
      for (int i = 0; i < 1024; i++) mref[i] = mem[i];
      for (int i = 0; i < 32; i++) regs[i] = 32'd0;
      repeat (3) @(negedge clk);
      #1;
      chk_bus(1'b1, 1'b0, 32'd0, 32'd0, "R1");     // fetch at 0 while in reset
      rst_n = 1'b1;
      pc = 32'd0; tag = "R1"; halted = 1'b0;
      for (int k = 0; k < 3000 && !halted; k++) begin
         ins = mref[pc[11:2]];
         op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
         ea = regs[rs] + sx(ins[15:0]);
         npc = pc + 32'd4;
         chk_bus(1'b1, 1'b0, pc, 32'd0, tag);
         tag = "R2";
         chk_bus(1'b0, 1'b0, 32'd0, 32'd0, "R3");
         case (op)
            6'd0: begin
               chk_bus(1'b0, 1'b0, 32'd0, 32'd0, "R3");
               chk_bus(1'b0, 1'b0, 32'd0, 32'd0, "R4");
               if (rd != 0) regs[rd] = alu_ref(ins[5:0], regs[rs], regs[rt]);
            end
            6'd35: begin
               chk_bus(1'b0, 1'b0, 32'd0, 32'd0, "R3");
               chk_bus(1'b1, 1'b0, ea, 32'd0, "R5");
               chk_bus(1'b0, 1'b0, 32'd0, 32'd0, "R3");
               if (rt != 0) regs[rt] = mref[ea[11:2]];
            end
            6'd43: begin
               chk_bus(1'b0, 1'b0, 32'd0, 32'd0, "R3");
               chk_bus(1'b0, 1'b1, ea, regs[rt], (rt == 0) ? "R8" : "R4,R5");
               mref[ea[11:2]] = regs[rt];
            end
            6'd4: begin
               chk_bus(1'b0, 1'b0, 32'd0, 32'd0, "R3");
               if (regs[rs] == regs[rt]) npc = npc + {sx(ins[15:0])[29:0], 2'b00};
               tag = "R6";
            end
            6'd2: begin
               chk_bus(1'b0, 1'b0, 32'd0, 32'd0, "R3");
               npc = {npc[31:28], ins[25:0], 2'b00};
               if (npc == pc) halted = 1'b1;
               tag = "R7";
            end
            default: tag = "R9";
         endcase
         pc = npc;
      end
      if (!halted) begin
         n_cmp++; n_bad++;
         $display("FAIL R2: model did not reach halt, actual pc=%h expected=halt loop", pc);
      end
      repeat (4) @(negedge clk);
      for (int i = 256; i < 512; i++) begin
         n_cmp++;
         if (mem[i] !== mref[i]) begin
            n_bad++;
            $display("FAIL R10: word %0d actual=%h expected=%h", i, mem[i], mref[i]);
         end
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule